// File: doc/BRIEF.md
# Two-Lane Delay-Commutator Shuffler

This block sits between two columns of radix-2 butterflies in a parallel feedforward FFT pipeline that carries four real-valued lanes per clock. The lanes arrive paired so that the two words of a pair are a distance D apart in the transform index. The next column needs pairs that are D/2 apart. The block first exchanges the two middle lanes. This splits the four-lane datapath into two independent pairs, (x0, x2) and (x1, x3). Each pair then passes through a delay commutator. The commutator holds a delay line of L words on its lower input, a second delay line of L words ahead of its upper output, and two multiplexers that share one control bit.

The control bit is taken from a phase counter that advances on every valid input and wraps after 2L valid words. The bit is 0 for the first L words of a frame and 1 for the next L. A start-of-frame pulse that arrives with a valid word forces that word to phase 0. Frames are 2L valid words long per lane, or a multiple of that. Frames may run back to back. Gaps in `in_valid` freeze the block. Outputs are combinational from the delay lines and the current inputs. The last half-frame leaves the block only when later valid words push it out.

A variant for the first pipeline stage, selected by `EXCHANGE_ONLY`, keeps the middle-lane exchange and nothing else.

Top module: `dc_shuffler`

## Requirements
- R1: After reset, `out_valid` stays low until valid words are presented.
- R2: Output lanes y0/y1 come from the pair formed by inputs x0 (upper) and x2 (lower). Output lanes y2/y3 come from the pair formed by x1 (upper) and x3 (lower).
- R3: Let a frame have phases p = 0..2L-1. At phase p+L (p < L), a pair emits (upper[p], upper[p+L]) on (hi, lo). At phase p of the following frame, the pair emits (lower[p], lower[p+L]) of the earlier frame.
- R4: `out_valid` rises first with the valid word numbered L after reset (counting from 0). This is L valid cycles after the first valid word.
- R5: Once raised, `out_valid` stays continuous across back-to-back frames whenever `in_valid` is high.
- R6: While `in_valid` is low, `out_valid` is low and no internal state advances. A gap therefore does not change the pairing.
- R7: `in_sof` together with `in_valid` places that word at phase 0, whatever the previous phase was.
- R8: With `EXCHANGE_ONLY` set, (y0, y1, y2, y3) = (x0, x2, x1, x3) and `out_valid` equals `in_valid` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input words are valid |
| in_sof | input | 1 | First word of a frame (used only with in_valid) |
| x0 | input | W | Lane 0, upper of pair A |
| x1 | input | W | Lane 1, upper of pair B |
| x2 | input | W | Lane 2, lower of pair A |
| x3 | input | W | Lane 3, lower of pair B |
| out_valid | output | 1 | Output words are valid |
| y0 | output | W | Pair A upper output |
| y1 | output | W | Pair A lower output |
| y2 | output | W | Pair B upper output |
| y3 | output | W | Pair B lower output |

## Verification
Outputs are combinational. The result belonging to valid word v is therefore due in the same cycle that word is presented. The bench samples it one nanosecond after driving the word. A word's upper-lane partner from the first half-frame reappears exactly L valid words later. A lower-lane pair from the earlier frame appears 2L and L valid words later. The bench keeps a history indexed by valid-word count, not by clock cycle, so random gaps do not shift its expectations. After a realigning start-of-frame, lower-lane pairs are checked only once a whole aligned frame lies behind the current word.

// File: rtl/dc_shuffler.sv
`timescale 1ns/1ps
module dc_shuffler #(
  parameter int W = 16,
  parameter int L = 4,
  parameter bit EXCHANGE_ONLY = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic         in_sof,
  input  logic [W-1:0] x0,
  input  logic [W-1:0] x1,
  input  logic [W-1:0] x2,
  input  logic [W-1:0] x3,
  output logic         out_valid,
  output logic [W-1:0] y0,
  output logic [W-1:0] y1,
  output logic [W-1:0] y2,
  output logic [W-1:0] y3
);
  localparam int CW = (2 * L > 2) ? $clog2(2 * L) : 1;
  localparam int FW = $clog2(L + 1);

  logic [CW-1:0] cnt;
  logic          primed;

  generate
    if (EXCHANGE_ONLY) begin : g_xchg
      assign y0 = x0;
      assign y1 = x2;
      assign y2 = x1;
      assign y3 = x3;
      assign out_valid = in_valid;
      assign cnt = '0;
      assign primed = 1'b1;
    end else begin : g_comm
      localparam logic [CW-1:0] HALF = CW'(L);
      localparam logic [CW-1:0] LAST = CW'(2 * L - 1);

      logic [CW-1:0] ph;
      logic          ctrl;
      logic [FW-1:0] fill;
      logic [W-1:0]  up [2];
      logic [W-1:0]  dn [2];
      logic [W-1:0]  hi [2];
      logic [W-1:0]  lo [2];

      assign ph   = in_sof ? '0 : cnt;
      assign ctrl = (ph >= HALF);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt  <= '0;
          fill <= '0;
        end else if (in_valid) begin
          cnt <= (ph == LAST) ? '0 : ph + CW'(1);
          if (!primed) fill <= fill + FW'(1);
        end
      end

      assign primed    = (fill == FW'(L));
      assign out_valid = in_valid & primed;

      assign up[0] = x0;
      assign up[1] = x1;
      assign dn[0] = x2;
      assign dn[1] = x3;

      for (genvar g = 0; g < 2; g++) begin : g_pair
        logic [W-1:0] ibuf [L];
        logic [W-1:0] obuf [L];

        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            for (int i = 0; i < L; i++) begin
              ibuf[i] <= '0;
              obuf[i] <= '0;
            end
          end else if (in_valid) begin
            ibuf[0] <= dn[g];
            obuf[0] <= ctrl ? ibuf[L-1] : up[g];
            for (int i = 1; i < L; i++) begin
              ibuf[i] <= ibuf[i-1];
              obuf[i] <= obuf[i-1];
            end
          end
        end

        assign hi[g] = obuf[L-1];
        assign lo[g] = ctrl ? up[g] : ibuf[L-1];
      end

      assign y0 = hi[0];
      assign y1 = lo[0];
      assign y2 = hi[1];
      assign y3 = lo[1];
    end
  endgenerate
endmodule

// File: rtl/dc_shuffler_chk.sv
`timescale 1ns/1ps
module dc_shuffler_chk #(
  parameter int L = 4,
  parameter bit EXCHANGE_ONLY = 1'b0,
  parameter int CW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_sof,
  input logic          out_valid,
  input logic [CW-1:0] cnt,
  input logic          primed
);
  // R6
  out_needs_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_valid);

  // R6
  gap_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(cnt) && $stable(primed)));

  // R7
  sof_realign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!EXCHANGE_ONLY && in_valid && in_sof) |=> (cnt == CW'(1)));

  // R5
  primed_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    primed |=> primed);

  // R4
  no_early_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !primed |-> !out_valid);

  // R3
  phase_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!EXCHANGE_ONLY && in_valid && !in_sof && cnt == CW'(2 * L - 1)) |=> (cnt == '0));
endmodule

bind dc_shuffler dc_shuffler_chk #(
  .L(L), .EXCHANGE_ONLY(EXCHANGE_ONLY), .CW(CW)
) chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
  .out_valid(out_valid), .cnt(cnt), .primed(primed)
);

// File: tb/dc_shuffler_test.sv
`timescale 1ns/1ps
module dc_shuffler_test;
  localparam int W = 16;
  localparam int L = 4;
  localparam int F = 2 * L;
  localparam int HMAX = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_sof = 1'b0;
  logic [W-1:0] x0 = '0, x1 = '0, x2 = '0, x3 = '0;
  logic out_valid, xv;
  logic [W-1:0] y0, y1, y2, y3, z0, z1, z2, z3;

  always #2 clk = ~clk;

  dc_shuffler #(.W(W), .L(L), .EXCHANGE_ONLY(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .x0(x0), .x1(x1), .x2(x2), .x3(x3),
    .out_valid(out_valid), .y0(y0), .y1(y1), .y2(y2), .y3(y3));

  dc_shuffler #(.W(W), .L(L), .EXCHANGE_ONLY(1'b1)) uut_x (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .x0(x0), .x1(x1), .x2(x2), .x3(x3),
    .out_valid(xv), .y0(z0), .y1(z1), .y2(z2), .y3(z3));

  int checks = 0, fails = 0;
  bit done = 1'b0;
  int vcnt = 0;
  int fp_next = 0;
  logic [W-1:0] h0 [HMAX], h1 [HMAX], h2 [HMAX], h3 [HMAX];
  int fpa [HMAX];

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int next_phase(input bit sof);
    return sof ? 0 : fp_next;
  endfunction

  task automatic step(input bit v, input bit s);
    int p, k;
    @(negedge clk);
    in_valid = v;
    in_sof = s;
    x0 = W'($urandom); x1 = W'($urandom); x2 = W'($urandom); x3 = W'($urandom);
    #1;
    // R8 exchange-only variant
    check("R8 valid", W'(xv), W'(v));
    check("R8 y1", z1, x2);
    check("R8 y2", z2, x1);
    // R4 R6 valid timing
    check("R4/R6 out_valid", W'(out_valid), W'(v && vcnt >= L));
    if (v) begin
      k = vcnt;
      p = next_phase(s);
      h0[k] = x0; h1[k] = x1; h2[k] = x2; h3[k] = x3; fpa[k] = p;
      if (k >= L && p >= L && fpa[k-L] == p - L) begin
        // R2 R3 upper-lane pairing
        check("R3 A hi", y0, h0[k-L]);
        check("R3 A lo", y1, h0[k]);
        check("R2 B hi", y2, h1[k-L]);
        check("R2 B lo", y3, h1[k]);
      end
      if (k >= F && p < L && fpa[k-F] == p && fpa[k-L] == p + L) begin
        // R2 R3 lower-lane pairing from previous frame
        check("R3 A hi", y0, h2[k-F]);
        check("R3 A lo", y1, h2[k-L]);
        check("R2 B hi", y2, h3[k-F]);
        check("R2 B lo", y3, h3[k-L]);
      end
      fp_next = (p == F - 1) ? 0 : p + 1;
      vcnt++;
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 out_valid", W'(out_valid), '0);
    rst_n = 1'b1;
    step(1'b0, 1'b0);
    check("R1 out_valid idle", W'(out_valid), '0);
    // R4 continuous first frames, first output at valid word L
    for (int i = 0; i < 3 * F; i++) step(1'b1, i % F == 0);
    // R5 R6 random gaps, back-to-back frames
    for (int i = 0; i < 1200; i++) begin
      bit v = ($urandom % 4) != 0;
      step(v, v && fp_next == 0);
    end
    // R7 realign mid-frame
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    for (int i = 0; i < 600; i++) begin
      bit v = ($urandom % 3) != 0;
      step(v, v && fp_next == 0);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule